// File: doc/BRIEF.md
# Long-Press Key Reset Controller

This block watches two active-low key status lines, a power key (index 0) and a home key (index 1). Whenever a key changes state and its interrupt-select bit is set, it latches a pending flag that drives that key's own active-high, level-sensitive interrupt line. The flag stays set until software writes 1 to it. Alongside the interrupts, a hold state machine asserts a one-cycle system reset request once the required keys have been held for a programmed number of seconds. The seconds are counted on a 1 Hz tick input.

Software reaches the block through a simple register port. Writes take one cycle and reads are combinational. Address 0 is a 16-bit control register. Address 1 returns the pending flags and the raw key status bits, and accepts write-one-to-clear of the pending flags.

The hold state machine has three states:
- `ST_IDLE`: no long press is in progress. It moves to `ST_HOLD` when the required keys are pressed.
- `ST_HOLD`: seconds are being counted. It returns to `ST_IDLE` on any release of a required key. It moves to `ST_FIRED` and emits the reset pulse when the count expires.
- `ST_FIRED`: the pulse has been given. It returns to `ST_IDLE` only once both keys read released.

Top module: `lpkey_reset_ctrl`

## Requirements
- R1: After reset, `key_irq` and `rst_req` are low, the control register reads 0x0000 and the pending bits read 0.
- R2: A read of address 1 returns the raw power key status in bit 4 and the raw home key status in bit 5, where 0 means pressed and 1 means released. The same read returns the pending flags in bits 1:0.
- R3: When key k changes level at a clock edge and control bit k (bit 0 for the power key, bit 1 for the home key) is set, pending bit k and `key_irq[k]` go high after that edge. They stay high afterwards.
- R4: With control bit k clear, a change of key k leaves `key_irq[k]` low.
- R5: A write to address 1 with data bit k set clears pending bit k after that edge. A new key change in the same cycle wins over the clear.
- R6: With control bit 6 set and bit 5 clear, holding the power key alone for the programmed duration produces a reset pulse. The pulse is due on the edge that counts the last tick.
- R7: With control bits 6 and 5 both set, a reset needs both keys held together. Holding the power key alone gives no pulse.
- R8: With bit 6 clear, whatever the state of bit 5, no reset pulse is ever produced.
- R9: The duration field is bits 9:8. Codes 0, 1, 2 and 3 require 8, 11, 14 and 5 ticks. The ticks are counted after the edge on which the hold begins.
- R10: Releasing a required key before expiry clears the count. A new hold then needs the full duration again.
- R11: `rst_req` is high for exactly one cycle. It cannot fire again until both keys have been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_n | input | 2 | Key status, bit 0 power, bit 1 home, 0 = pressed |
| sec_tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 pending) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 16 | Combinational read data |
| key_irq | output | 2 | Per-key level interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Results fall due at different times after a stimulus:
- A key change or a pending clear shows on `key_irq` one edge after the input is applied.
- The reset pulse appears one edge after the final counted tick and is gone one edge later.
- Read data follows the inputs in the same cycle.

The bench drives inputs on falling edges. It samples registered outputs on the next falling edge, and on every cycle compares them against a behavioural model that is stepped on the rising edge. Reads are sampled just after their address settles. The tick input is pulsed by hand, so each duration check counts the exact number of ticks before it expects the pulse.

// File: rtl/lpk_pkg.sv
package lpk_pkg;
    localparam int NUM_KEYS     = 2;
    localparam int REG_W        = 16;
    localparam int KEY_PWR      = 0;
    localparam int KEY_HOME     = 1;
    localparam int SEL_BASE     = 0;
    localparam int BIT_RST_HOME = 5;
    localparam int BIT_RST_PWR  = 6;
    localparam int DUR_LO       = 8;
    localparam int DUR_W        = 2;
    localparam int STAT_BASE    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FIRED = 2'd2
    } hold_st_e;
endpackage

// File: rtl/lpk_regs.sv
module lpk_regs
    import lpk_pkg::*;
#(
    parameter int NKEYS = NUM_KEYS,
    parameter int DW    = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic [NKEYS-1:0] key_n,
    output logic [DW-1:0]    ctrl,
    output logic [NKEYS-1:0] key_irq
);
    logic [DW-1:0]    ctrl_q;
    logic [NKEYS-1:0] key_prev;
    logic [NKEYS-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            key_prev <= '1;
        end else begin
            key_prev <= key_n;
            if (wr_en && !wr_addr) ctrl_q <= wr_data;
        end
    end

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        logic chg, clr;
        assign chg = (key_n[k] != key_prev[k]) && ctrl_q[SEL_BASE+k];
        assign clr = wr_en && wr_addr && wr_data[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pend_q[k] <= 1'b0;
            else if (chg) pend_q[k] <= 1'b1;
            else if (clr) pend_q[k] <= 1'b0;
        end

        // R3: a pending flag only rises when its select bit was set
        assert_irq_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[k]) |-> $past(ctrl_q[SEL_BASE+k]));
        // R5: a pending flag holds until written with a one
        assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[k] && !(wr_en && wr_addr && wr_data[k])) |=> pend_q[k]);
    end

    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data = ctrl_q;
        end else begin
            rd_data[NKEYS-1:0]          = pend_q;
            rd_data[STAT_BASE +: NKEYS] = key_n;
        end
    end

    assign ctrl    = ctrl_q;
    assign key_irq = pend_q;
endmodule

// File: rtl/lpk_hold_fsm.sv
module lpk_hold_fsm
    import lpk_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LIM0  = 8,
    parameter int LIM1  = 11,
    parameter int LIM2  = 14,
    parameter int LIM3  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       key_n,
    input  logic             pwr_en,
    input  logic             home_en,
    input  logic [DUR_W-1:0] dur,
    input  logic             sec_tick,
    output logic             rst_req
);
    hold_st_e         state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             held, fire;

    always_comb begin
        unique case (dur)
            2'd0:    lim = CNT_W'(LIM0);
            2'd1:    lim = CNT_W'(LIM1);
            2'd2:    lim = CNT_W'(LIM2);
            default: lim = CNT_W'(LIM3);
        endcase
    end

    assign held = pwr_en && !key_n[KEY_PWR] && (!home_en || !key_n[KEY_HOME]);
    assign fire = (state == ST_HOLD) && held && sec_tick &&
                  (({1'b0, cnt} + 1'b1) >= {1'b0, lim});

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (held) nxt = ST_HOLD;
            ST_HOLD:  if (!held) nxt = ST_IDLE;
                      else if (fire) nxt = ST_FIRED;
            ST_FIRED: if (&key_n) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
            if (state == ST_HOLD && held) begin
                if (sec_tick) cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // R11: the reset request lasts one cycle
    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R11: a pulse is always followed by the wait-for-release state
    assert_fired_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (state == ST_FIRED));
    // R6: a pulse needs the power key pressed and its enable on
    assert_fire_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(!key_n[KEY_PWR]) && $past(pwr_en)));
    // R10: the count is empty whenever no hold is running
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/lpkey_reset_ctrl.sv
module lpkey_reset_ctrl
    import lpk_pkg::*;
#(
    parameter int DUR0_S = 8,
    parameter int DUR1_S = 11,
    parameter int DUR2_S = 14,
    parameter int DUR3_S = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       key_n,
    input  logic             sec_tick,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [15:0]      wr_data,
    input  logic             rd_addr,
    output logic [15:0]      rd_data,
    output logic [1:0]       key_irq,
    output logic             rst_req
);
    localparam int MAX01 = (DUR0_S > DUR1_S) ? DUR0_S : DUR1_S;
    localparam int MAX23 = (DUR2_S > DUR3_S) ? DUR2_S : DUR3_S;
    localparam int MAXS  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAXS + 1);

    logic [REG_W-1:0] ctrl;

    lpk_regs #(.NKEYS(NUM_KEYS), .DW(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .key_n   (key_n),
        .ctrl    (ctrl),
        .key_irq (key_irq)
    );

    lpk_hold_fsm #(
        .CNT_W (CNT_W),
        .LIM0  (DUR0_S),
        .LIM1  (DUR1_S),
        .LIM2  (DUR2_S),
        .LIM3  (DUR3_S)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_n    (key_n),
        .pwr_en   (ctrl[BIT_RST_PWR]),
        .home_en  (ctrl[BIT_RST_HOME]),
        .dur      (ctrl[DUR_LO +: DUR_W]),
        .sec_tick (sec_tick),
        .rst_req  (rst_req)
    );
endmodule

// File: tb/lpkey_reset_ctrl_tb.sv
module lpkey_reset_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  key_n = 2'b11;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  key_irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpkey_reset_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .sec_tick(sec_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .key_irq(key_irq), .rst_req(rst_req)
    );

    // behavioural reference
    logic [15:0] m_ctrl;
    logic [1:0]  m_prev, m_pend;
    int          m_phase, m_ticks;
    logic        m_rst;

    function automatic int dur_ticks(input logic [1:0] code);
        case (code)
            2'd0: return 8;
            2'd1: return 11;
            2'd2: return 14;
            default: return 5;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_prev = 2'b11; m_pend = '0;
            m_phase = 0; m_ticks = 0; m_rst = 1'b0;
        end else begin
            bit want;
            want = m_ctrl[6] && !key_n[0] && (!m_ctrl[5] || !key_n[1]);
            m_rst = 1'b0;
            for (int k = 0; k < 2; k++) begin
                if (key_n[k] != m_prev[k] && m_ctrl[k]) m_pend[k] = 1'b1;
                else if (wr_en && wr_addr && wr_data[k]) m_pend[k] = 1'b0;
            end
            if (m_phase == 0) begin
                if (want) begin m_phase = 1; m_ticks = 0; end
            end else if (m_phase == 1) begin
                if (!want) begin m_phase = 0; m_ticks = 0; end
                else if (sec_tick) begin
                    m_ticks++;
                    if (m_ticks >= dur_ticks(m_ctrl[9:8])) begin m_phase = 2; m_rst = 1'b1; end
                end
            end else if (key_n == 2'b11) begin
                m_phase = 0; m_ticks = 0;
            end
            m_prev = key_n;
            if (wr_en && !wr_addr) m_ctrl = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 key_irq vs model", {30'd0, key_irq}, {30'd0, m_pend});
            chk("R11 rst_req vs model", {31'd0, rst_req}, {31'd0, m_rst});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            sec_tick = 1'b1; step(1);
            sec_tick = 1'b0; step(1);
        end
    endtask

    // n-1 ticks with no pulse, then the last tick gives a one-cycle pulse
    task automatic expect_fire(input string tag, input int n);
        tick(n - 1);
        chk({tag, " no early pulse"}, {31'd0, rst_req}, 32'd0);
        sec_tick = 1'b1; step(1); sec_tick = 1'b0;
        chk({tag, " pulse on last tick"}, {31'd0, rst_req}, 32'd1);
        step(1);
        chk({tag, " pulse one cycle"}, {31'd0, rst_req}, 32'd0);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 irq after reset", {30'd0, key_irq}, 32'd0);
        chk("R1 rst_req after reset", {31'd0, rst_req}, 32'd0);
        rd(1'b0, d); chk("R1 ctrl after reset", {16'd0, d}, 32'h0000);
        rd(1'b1, d); chk("R1 pending after reset", {30'd0, d[1:0]}, 32'd0);

        // R3 / R2: interrupts with both selects on
        wr(1'b0, 16'h0003);
        rd(1'b0, d); chk("R1 ctrl readback", {16'd0, d}, 32'h0003);
        key_n = 2'b10; step(1);
        chk("R3 power irq after press", {30'd0, key_irq}, 32'd1);
        rd(1'b1, d); chk("R2 status power pressed", {30'd0, d[5:4]}, 32'b10);
        chk("R2 pending bits", {30'd0, d[1:0]}, 32'b01);
        step(3);
        chk("R3 irq stays high", {30'd0, key_irq}, 32'd1);
        wr(1'b1, 16'h0001);
        chk("R5 clear power pending", {30'd0, key_irq}, 32'd0);
        key_n = 2'b00; step(1);
        chk("R3 home irq on press", {30'd0, key_irq}, 32'b10);
        rd(1'b1, d); chk("R2 status both pressed", {30'd0, d[5:4]}, 32'b00);
        // R5: set wins over clear in same cycle
        key_n = 2'b01; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h0001;
        step(1); wr_en = 1'b0; wr_data = '0;
        chk("R5 set beats clear", {30'd0, key_irq}, 32'b11);
        wr(1'b1, 16'h0003);
        chk("R5 clear both", {30'd0, key_irq}, 32'd0);

        // R4: selects off
        wr(1'b0, 16'h0000);
        key_n = 2'b11; step(1);
        key_n = 2'b00; step(1);
        chk("R4 change ignored", {30'd0, key_irq}, 32'd0);
        key_n = 2'b11; step(2);

        // R6 / R9 power-only, code 3
        wr(1'b0, 16'h0340);
        key_n = 2'b10; step(1);
        expect_fire("R9 code3 5 ticks R6", 5);
        // R11: no refire while held, nor while home still held
        tick(12);
        chk("R11 no refire held", {31'd0, rst_req}, 32'd0);
        key_n = 2'b00; step(1); key_n = 2'b01; step(1);
        tick(6);
        chk("R11 no refire with home held", {31'd0, rst_req}, 32'd0);
        key_n = 2'b11; step(1);
        key_n = 2'b10; step(1);
        expect_fire("R11 refire after release", 5);
        key_n = 2'b11; step(1);

        // R9 other codes
        for (int c = 0; c < 3; c++) begin
            wr(1'b0, 16'h0040 | (16'(c) << 8));
            key_n = 2'b10; step(1);
            expect_fire("R9 code duration", dur_ticks(2'(c)));
            key_n = 2'b11; step(1);
        end

        // R10 early release, code 0
        wr(1'b0, 16'h0040);
        key_n = 2'b10; step(1);
        tick(5);
        key_n = 2'b11; step(1);
        key_n = 2'b10; step(1);
        tick(7);
        chk("R10 count restarted", {31'd0, rst_req}, 32'd0);
        tick(1);
        key_n = 2'b11; step(1);

        // R7 both keys, code 1
        wr(1'b0, 16'h0160);
        key_n = 2'b10; step(1);
        tick(14);
        chk("R7 power alone no pulse", {31'd0, rst_req}, 32'd0);
        key_n = 2'b00; step(1);
        expect_fire("R7 both held", 11);
        key_n = 2'b11; step(1);

        // R8 disabled variants
        wr(1'b0, 16'h0320);
        key_n = 2'b00; step(1);
        tick(16);
        chk("R8 home-only enable no pulse", {31'd0, rst_req}, 32'd0);
        key_n = 2'b11; step(1);
        wr(1'b0, 16'h0300);
        key_n = 2'b00; step(1);
        tick(16);
        chk("R8 disabled no pulse", {31'd0, rst_req}, 32'd0);
        key_n = 2'b11; step(2);

        finish_run();
    end
endmodule